// File: doc/BRIEF.md
# Packed Integer Adder with Lane Saturation

This block adds or subtracts two 64-bit operands as a set of independent packed integer lanes. The caller picks the lane size per operation (eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes) and the overflow treatment: plain modular wraparound, clamping to the signed range, or clamping to the unsigned range. No carry or borrow ever passes from one lane into the next.

An operation is presented with `in_valid` high for one cycle. Exactly one cycle later the lane results appear on `result` with `out_valid` high. When no operation is presented, `result` keeps its last value. It is used as a single-cycle execution stage for media-style integer arithmetic, such as pixel blending or audio mixing, where clamping removes wraparound artefacts.

Top module: `psimd_addsat`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. `result` changes only after such a cycle. After reset both are zero.
- R2: Encodings: `lane_sel` 00 selects 8-bit lanes, 01 selects 16-bit lanes, and 10 or 11 select 32-bit lanes. `mode_sel` 00 selects wraparound, 01 signed saturation, 10 unsigned saturation and 11 wraparound. `sub_en`=1 computes `opa - opb` per lane; `sub_en`=0 computes `opa + opb`. Lane k occupies bits [k*W+W-1 : k*W].
- R3: In wraparound addition each lane keeps the low W bits of its sum and drops its carry (byte A0h+70h = 10h, word FFFFh+8000h = 7FFFh, and FFh+01h in one byte leaves the next byte unchanged).
- R4: With 32-bit lanes the saturating modes are ignored and both lanes wrap (7FFFFFFFh+1 = 80000000h, FFFFFFFFh+1 = 00000000h).
- R5: Unsigned-saturating addition that overflows a lane yields all ones in that lane (word FFF4h+1123h = FFFFh).
- R6: Unsigned-saturating subtraction that would go below zero yields zero in that lane; a lane that does not underflow gives the exact difference.
- R7: Signed-saturating addition clamps a positive overflow to the largest positive lane value and a negative overflow to the most negative lane value. Word 7FF4h+0050h = 7FFFh; bytes 8080555580805555h + 009033FF009033FFh = 80807F5480807F54h.
- R8: Signed-saturating subtraction clamps the same way (word 8000h-0001h = 8000h, word 7FFFh-FFFFh = 7FFFh).
- R9: In wraparound subtraction each lane keeps the low W bits of its difference, and a borrow never reaches the neighbouring lane (byte 00h-01h = FFh with the byte above unchanged).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| opa | input | 64 | First operand (minuend on subtract) |
| opb | input | 64 | Second operand (subtrahend on subtract) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| lane_sel | input | 2 | Lane size select |
| mode_sel | input | 2 | Overflow treatment select |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Registered packed lane results |

## Verification
Within a single operation some lanes saturate while their neighbours must not: one lane's clamp and the next lane's exact result are produced in the same cycle by the same carry chain. The bench provokes this with packed vectors in which some lanes overflow and others do not, such as the mixed signed byte vector and a word subtraction where one lane underflows and the other overflows. It then compares every lane against values worked out by hand and against a lane-by-lane integer model. The lane size and mode selects are also swept with random operands, so that clamps and carry cuts of every size occur together.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

   localparam int GRAN_W  = 8;
   localparam int HALF_W  = 16;
   localparam int FULL_W  = 32;

   typedef enum logic [1:0] {
      SZ_BYTE   = 2'b00,
      SZ_WORD   = 2'b01,
      SZ_DWORD  = 2'b10,
      SZ_DWORD2 = 2'b11
   } size_e;

   typedef enum logic [1:0] {
      SAT_NONE     = 2'b00,
      SAT_SIGNED   = 2'b01,
      SAT_UNSIGNED = 2'b10,
      SAT_NONE2    = 2'b11
   } sat_e;

endpackage

// File: rtl/psimd_seg_adder.sv
module psimd_seg_adder
   import psimd_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]                a_i,
   input  logic [DATA_W-1:0]                b_i,
   input  logic                             sub_i,
   input  size_e                            size_i,
   output logic [DATA_W-1:0]                sum_o,
   output logic [DATA_W/GRAN_W-1:0]         gcarry_o
);

   localparam int NGRAN = DATA_W / GRAN_W;

   for (genvar g = 0; g < NGRAN; g++) begin : g_gran
      localparam bit HALF_START = (g % (HALF_W / GRAN_W)) == 0;
      localparam bit FULL_START = (g % (FULL_W / GRAN_W)) == 0;

      logic [GRAN_W-1:0] a_s;
      logic [GRAN_W-1:0] bx_s;
      logic              cin;

      assign a_s  = a_i[g*GRAN_W +: GRAN_W];
      assign bx_s = sub_i ? ~b_i[g*GRAN_W +: GRAN_W] : b_i[g*GRAN_W +: GRAN_W];

      if (g == 0) begin : g_first
         assign cin = sub_i;
      end else begin : g_rest
         logic cut;
         assign cut = (size_i == SZ_BYTE)
                    | ((size_i == SZ_WORD) & HALF_START)
                    | ((size_i != SZ_BYTE) & (size_i != SZ_WORD) & FULL_START);
         assign cin = cut ? sub_i : gcarry_o[g-1];
      end

      assign {gcarry_o[g], sum_o[g*GRAN_W +: GRAN_W]} =
         {1'b0, a_s} + {1'b0, bx_s} + {{GRAN_W{1'b0}}, cin};
   end

endmodule

// File: rtl/psimd_lane_sat.sv
module psimd_lane_sat
   import psimd_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LW     = 8
) (
   input  logic [DATA_W-1:0]     sum_i,
   input  logic [DATA_W/LW-1:0]  a_sign_i,
   input  logic [DATA_W/LW-1:0]  b_sign_i,
   input  logic [DATA_W/LW-1:0]  carry_i,
   input  logic                  sub_i,
   input  sat_e                  mode_i,
   output logic [DATA_W-1:0]     res_o
);

   localparam int NLANE = DATA_W / LW;
   localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
   localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
   localparam logic [LW-1:0] UMAX = {LW{1'b1}};
   localparam logic [LW-1:0] UMIN = {LW{1'b0}};

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      logic [LW-1:0] raw;
      logic          s_ovf;
      logic          u_ovf;

      assign raw   = sum_i[l*LW +: LW];
      assign s_ovf = (a_sign_i[l] == b_sign_i[l]) && (raw[LW-1] != a_sign_i[l]);
      assign u_ovf = carry_i[l] ^ sub_i;

      always_comb begin
         case (mode_i)
            SAT_SIGNED:   res_o[l*LW +: LW] = s_ovf ? (a_sign_i[l] ? SMIN : SMAX) : raw;
            SAT_UNSIGNED: res_o[l*LW +: LW] = u_ovf ? (sub_i ? UMIN : UMAX) : raw;
            default:      res_o[l*LW +: LW] = raw;
         endcase
      end
   end

endmodule

// File: rtl/psimd_addsat.sv
module psimd_addsat
   import psimd_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              sub_en,
   input  logic [1:0]        lane_sel,
   input  logic [1:0]        mode_sel,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);

   localparam int NGRAN = DATA_W / GRAN_W;
   localparam int NHALF = DATA_W / HALF_W;
   localparam int GPH   = HALF_W / GRAN_W;

   initial begin
      if (DATA_W < FULL_W || (DATA_W % FULL_W) != 0)
         $fatal(1, "psimd_addsat: DATA_W must be a positive multiple of %0d", FULL_W);
   end

   size_e size_q;
   sat_e  mode_q;
   assign size_q = size_e'(lane_sel);
   assign mode_q = sat_e'(mode_sel);

   logic [DATA_W-1:0] sum;
   logic [NGRAN-1:0]  gcarry;

   psimd_seg_adder #(.DATA_W(DATA_W)) u_adder (
      .a_i      (opa),
      .b_i      (opb),
      .sub_i    (sub_en),
      .size_i   (size_q),
      .sum_o    (sum),
      .gcarry_o (gcarry)
   );

   logic [NGRAN-1:0] a8, b8;
   logic [NHALF-1:0] a16, b16, c16;

   for (genvar l = 0; l < NGRAN; l++) begin : g_byte_sign
      assign a8[l] = opa[l*GRAN_W + GRAN_W - 1];
      assign b8[l] = opb[l*GRAN_W + GRAN_W - 1] ^ sub_en;
   end

   for (genvar l = 0; l < NHALF; l++) begin : g_half_sign
      assign a16[l] = opa[l*HALF_W + HALF_W - 1];
      assign b16[l] = opb[l*HALF_W + HALF_W - 1] ^ sub_en;
      assign c16[l] = gcarry[l*GPH + GPH - 1];
   end

   logic [DATA_W-1:0] res8, res16;

   psimd_lane_sat #(.DATA_W(DATA_W), .LW(GRAN_W)) u_sat8 (
      .sum_i    (sum),
      .a_sign_i (a8),
      .b_sign_i (b8),
      .carry_i  (gcarry),
      .sub_i    (sub_en),
      .mode_i   (mode_q),
      .res_o    (res8)
   );

   psimd_lane_sat #(.DATA_W(DATA_W), .LW(HALF_W)) u_sat16 (
      .sum_i    (sum),
      .a_sign_i (a16),
      .b_sign_i (b16),
      .carry_i  (c16),
      .sub_i    (sub_en),
      .mode_i   (mode_q),
      .res_o    (res16)
   );

   logic [DATA_W-1:0] pick;
   always_comb begin
      case (size_q)
         SZ_BYTE: pick = res8;
         SZ_WORD: pick = res16;
         default: pick = sum;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= pick;
      end
   end

endmodule

// File: rtl/psimd_addsat_chk.sv
module psimd_addsat_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic              sub_en,
   input logic [1:0]        lane_sel,
   input logic [1:0]        mode_sel,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);

   a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r1_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   a_r4_dword_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel[1] && !sub_en)
      |=> result[31:0] == 32'($past(opa[31:0]) + $past(opb[31:0])));

   a_r4_dword_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel[1] && !sub_en)
      |=> result[DATA_W-1 -: 32] == 32'($past(opa[DATA_W-1 -: 32]) + $past(opb[DATA_W-1 -: 32])));

   a_r5_usat_add_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel == 2'b00 && mode_sel == 2'b10 && !sub_en)
      |=> result[7:0] >= $past(opa[7:0]));

   a_r6_usat_sub_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel == 2'b00 && mode_sel == 2'b10 && sub_en)
      |=> result[7:0] <= $past(opa[7:0]));

   a_r7_ssat_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel == 2'b01 && mode_sel == 2'b01 && !sub_en && !opa[15] && !opb[15])
      |=> !result[15]);

endmodule

bind psimd_addsat psimd_addsat_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/psimd_addsat_bench.sv
module psimd_addsat_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        sub_en = 1'b0;
   logic [1:0]  lane_sel = 2'b00;
   logic [1:0]  mode_sel = 2'b00;
   logic        out_valid;
   logic [63:0] result;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   psimd_addsat u_psimd_addsat (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
      .sub_en(sub_en), .lane_sel(lane_sel), .mode_sel(mode_sel),
      .out_valid(out_valid), .result(result)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one operation at a falling edge; returns at the falling edge after capture
   task automatic do_op(input logic [63:0] a, input logic [63:0] b, input logic s,
                        input logic [1:0] sz, input logic [1:0] md);
      @(negedge clk);
      opa = a; opb = b; sub_en = s; lane_sel = sz; mode_sel = md; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [63:0] ref_op(input logic [63:0] a, input logic [63:0] b,
                                          input logic s, input logic [1:0] sz, input logic [1:0] md);
      int lw;
      logic [63:0] r;
      lw = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
      r = '0;
      for (int base = 0; base < 64; base += lw) begin
         longint ua, ub, sa, sb, res, umax, smax, smin;
         ua = 0; ub = 0;
         for (int k = 0; k < lw; k++) begin
            ua[k] = a[base+k];
            ub[k] = b[base+k];
         end
         umax = (longint'(1) << lw) - 1;
         smax = (longint'(1) << (lw-1)) - 1;
         smin = -(longint'(1) << (lw-1));
         if (md == 2'b01 && lw < 32) begin
            sa = (ua > smax) ? ua - (longint'(1) << lw) : ua;
            sb = (ub > smax) ? ub - (longint'(1) << lw) : ub;
            res = s ? sa - sb : sa + sb;
            if (res > smax) res = smax;
            if (res < smin) res = smin;
         end else if (md == 2'b10 && lw < 32) begin
            res = s ? ua - ub : ua + ub;
            if (res > umax) res = umax;
            if (res < 0) res = 0;
         end else begin
            res = s ? ua - ub : ua + ub;
         end
         for (int k = 0; k < lw; k++) r[base+k] = res[k];
      end
      return r;
   endfunction

   task automatic t_reset_and_handshake();
      chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
      chk("R1 reset result", result, 64'd0);
      do_op(64'h0000_0000_0000_00A0, 64'h0000_0000_0000_0070, 1'b0, 2'b00, 2'b00);
      chk("R1 out_valid after op", {63'd0, out_valid}, 64'd1);
      @(negedge clk);
      opa = 64'h1234_5678_9ABC_DEF0; opb = 64'hFFFF_FFFF_FFFF_FFFF;
      @(negedge clk);
      chk("R1 out_valid idle", {63'd0, out_valid}, 64'd0);
      chk("R1 result held while idle", result, 64'h0000_0000_0000_0010);
   endtask

   task automatic t_wrap_add();
      do_op(64'h0000_0000_0000_00A0, 64'h0000_0000_0000_0070, 1'b0, 2'b00, 2'b00);
      chk("R3 byte A0+70", result, 64'h0000_0000_0000_0010);
      do_op(64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_8000, 1'b0, 2'b01, 2'b00);
      chk("R3 word FFFF+8000", result, 64'h0000_0000_0000_7FFF);
      do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'b00, 2'b00);
      chk("R3 byte carry cut", result, 64'h0000_0000_0000_0000);
      do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'b01, 2'b11);
      chk("R3 R2 word carry cut mode 11", result, 64'h0100_0100_0100_0100);
      do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'b11, 2'b00);
      chk("R3 R2 dword carry cut sel 11", result, 64'h0101_0100_0101_0100);
   endtask

   task automatic t_wrap_sub();
      do_op(64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, 1'b1, 2'b00, 2'b00);
      chk("R9 byte borrow cut", result, 64'h0000_0000_0000_01FF);
      do_op(64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 2'b01, 2'b00);
      chk("R9 word borrow cut", result, 64'h0000_0001_0000_FFFF);
   endtask

   task automatic t_dword_ignores_sat();
      do_op(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 1'b0, 2'b10, 2'b01);
      chk("R4 dword signed mode wraps", result, 64'h0000_0000_8000_0000);
      do_op(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 1'b0, 2'b10, 2'b10);
      chk("R4 dword unsigned mode wraps", result, 64'h0000_0000_8000_0000);
   endtask

   task automatic t_unsigned_sat();
      do_op(64'h0000_0000_0000_FFF4, 64'h0000_0000_0000_1123, 1'b0, 2'b01, 2'b10);
      chk("R5 word FFF4+1123", result, 64'h0000_0000_0000_FFFF);
      do_op(64'h0000_0000_0030_0510, 64'h0000_0000_0000_0820, 1'b1, 2'b00, 2'b10);
      chk("R6 byte underflow to zero", result, 64'h0000_0000_0030_0000);
   endtask

   task automatic t_signed_sat();
      do_op(64'h0000_0000_0000_7FF4, 64'h0000_0000_0000_0050, 1'b0, 2'b01, 2'b01);
      chk("R7 word 7FF4+0050", result, 64'h0000_0000_0000_7FFF);
      do_op(64'h8080_5555_8080_5555, 64'h0090_33FF_0090_33FF, 1'b0, 2'b00, 2'b01);
      chk("R7 mixed byte vector", result, 64'h8080_7F54_8080_7F54);
      do_op(64'h0000_0000_7FFF_8000, 64'h0000_0000_FFFF_0001, 1'b1, 2'b01, 2'b01);
      chk("R8 word sub both clamps", result, 64'h0000_0000_7FFF_8000);
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 400; i++) begin
         logic [63:0] a, b;
         logic s;
         logic [1:0] sz, md;
         a  = {$urandom, $urandom};
         b  = {$urandom, $urandom};
         s  = 1'($urandom);
         sz = 2'($urandom);
         md = 2'($urandom);
         do_op(a, b, s, sz, md);
         chk($sformatf("R2 R5 R6 R7 R8 sweep a=%h b=%h s=%0d sz=%0d md=%0d", a, b, s, sz, md),
             result, ref_op(a, b, s, sz, md));
      end
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_handshake();
      t_wrap_add();
      t_wrap_sub();
      t_dword_ignores_sat();
      t_unsigned_sat();
      t_signed_sat();
      t_sweep();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule